// File: doc/BRIEF.md
# Code/Data RAM Bank Steering

This block sits between a microcontroller with a multiplexed address/data bus and one external RAM that holds both program code and data. The RAM's top address line, called the bank line here, splits the chip in two: the upper half holds code and the lower half holds data. Early in every bus cycle the block works out whether the cycle fetches code or accesses data, and it drives the bank line to match before any RAM strobe goes active.

The address-latch strobe is sampled by the system clock through a short chain of flip-flops. While the first stage of the chain is high, the bank line is held at the code level. When the last stage falls, the bank register captures the program-fetch strobe and holds that value until the next address-latch pulse. This fixes the bank line ahead of the write strobe, so the RAM's address-setup-to-write limit is never broken.

The block also builds the RAM output enable from the two read strobes and passes the write strobe through unchanged. A boot input pins the bank line to the code level, so a loader can write downloaded code into the upper half.

Top module: `ram_bank_steer`

## Requirements
- R1: With the default polarity (CODE_HIGH = 1), `bank_sel` = 1 selects the code half and `bank_sel` = 0 selects the data half.
- R2: A synchronous active-low reset clears the address-latch sampling chain and the bank register. After reset, with `boot_force` low and `ale` low, `bank_sel` shows the data level.
- R3: From the first rising clock edge at which `ale` is sampled high, `bank_sel` shows the code level, and it keeps showing it while `ale` stays high.
- R4: At the second rising edge after `ale` is first sampled low, the bank register captures the cycle type: code if `fetch_n` is low, data if it is high. `bank_sel` then holds that value until `ale` next rises, so it is valid before any strobe that falls two or more clocks after `ale` falls.
- R6: While `wr_n` stays low, `bank_sel` does not change, provided `ale` has stayed low since the capture and `boot_force` is steady.
- R7: `ram_oe_n` is low exactly when `rd_n` or `fetch_n` is low, so it is the AND of the two active-low strobes.
- R8: `ram_we_n` follows `wr_n` with no clock delay.
- R9: `boot_force` high drives `bank_sel` to the code level at once. It overrides reset, the sampling chain and the captured value.
- R10: When `boot_force` is released, `bank_sel` returns to the value the bank register last captured, or to the data level after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ale | input | 1 | Address-latch strobe from the controller, active high |
| fetch_n | input | 1 | Program-fetch read strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| boot_force | input | 1 | Forces the bank line to the code level |
| bank_sel | output | 1 | RAM top address line (bank select) |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
Fetch cycles, data reads and data writes are run in random order. Each has a random gap between the fall of the address-latch strobe and the fall of its strobe, and a random strobe width. A fetch that follows a data cycle, or a data cycle that follows a fetch, shows whether the register really captures a fresh value or only keeps a stale one. Checking each clock during a long write tells a stable bank line apart from one that changes during the write. The boot override is applied both during reset and during random cycles. Releasing it shows that the block goes back to the captured value and not to a fixed one. A sweep through all four combinations of the two read strobes confirms the output-enable combine.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   // Kind of bus cycle held in the bank register.
   typedef enum logic {
      KIND_DATA = 1'b0,
      KIND_CODE = 1'b1
   } bank_kind_e;

   // Minimum depth of the address-latch sampling chain: one stage presets, a later stage captures.
   localparam int MIN_ALE_STAGES = 2;

endpackage

// File: rtl/rbs_ale_pipe.sv
module rbs_ale_pipe #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   output logic preset_o,
   output logic capture_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] stg_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[i] <= 1'b0;
               else        stg_q[i] <= ale;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[i] <= 1'b0;
               else        stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   // The first stage holds the bank at code; the capture fires as the last stage falls.
   assign preset_o  = stg_q[0];
   assign capture_o = stg_q[LAST] & ~stg_q[LAST-1];

endmodule

// File: rtl/rbs_bank_reg.sv
module rbs_bank_reg (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                preset,
   input  logic                capture,
   input  logic                fetch_n,
   output rbs_pkg::bank_kind_e kind_q
);
   import rbs_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)       kind_q <= KIND_DATA;
      else if (preset)  kind_q <= KIND_CODE;
      else if (capture) kind_q <= fetch_n ? KIND_DATA : KIND_CODE;
   end

endmodule

// File: rtl/rbs_strobe_mux.sv
module rbs_strobe_mux #(
   parameter bit CODE_HIGH = 1'b1
) (
   input  logic                boot_force,
   input  logic                preset,
   input  rbs_pkg::bank_kind_e kind_q,
   input  logic                fetch_n,
   input  logic                rd_n,
   input  logic                wr_n,
   output logic                bank_sel,
   output logic                ram_oe_n,
   output logic                ram_we_n
);
   import rbs_pkg::*;

   logic code_sel;

   // The override and the preset both win over the held cycle type.
   assign code_sel = boot_force | preset | (kind_q == KIND_CODE);

   generate
      if (CODE_HIGH) begin : g_pol_high
         assign bank_sel = code_sel;
      end else begin : g_pol_low
         assign bank_sel = ~code_sel;
      end
   endgenerate

   assign ram_oe_n = rd_n & fetch_n;
   assign ram_we_n = wr_n;

endmodule

// File: rtl/ram_bank_steer.sv
module ram_bank_steer #(
   parameter int ALE_STAGES = 2,
   parameter bit CODE_HIGH  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   input  logic fetch_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic boot_force,
   output logic bank_sel,
   output logic ram_oe_n,
   output logic ram_we_n
);
   import rbs_pkg::*;

   generate
      if (ALE_STAGES < MIN_ALE_STAGES) begin : g_bad_stages
         $error("ram_bank_steer: ALE_STAGES must be at least 2");
      end
   endgenerate

   logic       preset;
   logic       capture;
   bank_kind_e kind_q;

   rbs_ale_pipe #(.STAGES(ALE_STAGES)) pipe_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ale       (ale),
      .preset_o  (preset),
      .capture_o (capture)
   );

   rbs_bank_reg breg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .preset  (preset),
      .capture (capture),
      .fetch_n (fetch_n),
      .kind_q  (kind_q)
   );

   rbs_strobe_mux #(.CODE_HIGH(CODE_HIGH)) mux_i (
      .boot_force (boot_force),
      .preset     (preset),
      .kind_q     (kind_q),
      .fetch_n    (fetch_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .bank_sel   (bank_sel),
      .ram_oe_n   (ram_oe_n),
      .ram_we_n   (ram_we_n)
   );

endmodule

// File: rtl/ram_bank_steer_chk.sv
module ram_bank_steer_chk #(
   parameter int ALE_STAGES = 2,
   parameter bit CODE_HIGH  = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic ale,
   input logic fetch_n,
   input logic rd_n,
   input logic wr_n,
   input logic boot_force,
   input logic bank_sel,
   input logic ram_oe_n,
   input logic ram_we_n
);
   localparam logic CODE_LVL = CODE_HIGH;
   localparam logic DATA_LVL = ~CODE_HIGH;
   localparam int   SAT      = ALE_STAGES + 1;
   localparam int   CW       = $clog2(SAT + 1);

   // Counts edges since the address-latch strobe was last seen high, and stops at SAT.
   logic [CW-1:0] quiet_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || ale)            quiet_cnt <= '0;
      else if (quiet_cnt != CW'(SAT)) quiet_cnt <= quiet_cnt + 1'b1;
   end

   AST_RESET_DATA: assert property (@(posedge clk)
      !rst_n |=> (boot_force || bank_sel == DATA_LVL));  // R2

   AST_ALE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ale) && $past(rst_n)) |-> bank_sel == CODE_LVL);  // R3

   AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n) && quiet_cnt == CW'(SAT) && $stable(boot_force))
      |-> $stable(bank_sel));  // R6

   AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_oe_n) |-> (!rd_n || !fetch_n));  // R7

   AST_WE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> $rose(ram_we_n));  // R8

   AST_BOOT_CODE: assert property (@(posedge clk)
      boot_force |-> bank_sel == CODE_LVL);  // R9

endmodule

bind ram_bank_steer ram_bank_steer_chk #(
   .ALE_STAGES (ALE_STAGES),
   .CODE_HIGH  (CODE_HIGH)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ale        (ale),
   .fetch_n    (fetch_n),
   .rd_n       (rd_n),
   .wr_n       (wr_n),
   .boot_force (boot_force),
   .bank_sel   (bank_sel),
   .ram_oe_n   (ram_oe_n),
   .ram_we_n   (ram_we_n)
);

// File: tb/ram_bank_steer_tb_top.sv
`timescale 1ns/1ps
module ram_bank_steer_tb_top;

   localparam int NUM_CYCLES = 300;
   localparam int WDOG_CLKS  = 150000;

   logic clk = 1'b0;
   logic rst_n, ale, fetch_n, rd_n, wr_n, boot_force;
   logic bank_sel, ram_oe_n, ram_we_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ram_bank_steer dut_i (
      .clk(clk), .rst_n(rst_n), .ale(ale), .fetch_n(fetch_n),
      .rd_n(rd_n), .wr_n(wr_n), .boot_force(boot_force),
      .bank_sel(bank_sel), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
   );

   // Bench model of the expected values.
   function automatic logic exp_bank(input bit is_code, input bit boot);
      return (boot || is_code) ? 1'b1 : 1'b0;
   endfunction

   function automatic logic exp_oe(input logic r, input logic f);
      return r & f;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // kind: 0 = fetch, 1 = data read, 2 = data write
   task automatic bus_cycle(input int kind, input bit boot);
      bit   is_code = (kind == 0);
      logic held;
      int   gap  = $urandom % 3;
      int   hold = 2 + ($urandom % 4);
      boot_force = boot;
      ale = 1'b1;
      tick();
      chk("R3 ale high", bank_sel, 1'b1);
      tick();
      chk("R3 ale held", bank_sel, 1'b1);
      ale = 1'b0;
      if (is_code) fetch_n = 1'b0;
      tick();
      tick();
      chk("R1 R4 captured", bank_sel, exp_bank(is_code, boot));
      if (is_code) begin
         for (int i = 0; i < hold; i++) begin
            chk("R7 fetch oe", ram_oe_n, exp_oe(rd_n, fetch_n));
            chk("R4 fetch hold", bank_sel, exp_bank(1'b1, boot));
            tick();
         end
         fetch_n = 1'b1;
      end else begin
         for (int i = 0; i < gap; i++) tick();
         chk("R4 before strobe", bank_sel, exp_bank(1'b0, boot));
         held = bank_sel;
         if (kind == 1) rd_n = 1'b0;
         else           wr_n = 1'b0;
         for (int i = 0; i < hold; i++) begin
            tick();
            if (kind == 1) begin
               chk("R7 read oe", ram_oe_n, 1'b0);
            end else begin
               chk("R8 write we", ram_we_n, 1'b0);
               chk("R6 write stable", bank_sel, held);
            end
         end
         rd_n = 1'b1;
         wr_n = 1'b1;
      end
      tick();
      chk("R8 we idle", ram_we_n, 1'b1);
      if (boot) begin
         boot_force = 1'b0;
         tick();
         chk("R10 release", bank_sel, exp_bank(is_code, 1'b0));
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; ale = 1'b0; fetch_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      boot_force = 1'b0;
      repeat (3) tick();
      chk("R2 reset bank", bank_sel, 1'b0);
      chk("R7 reset oe", ram_oe_n, 1'b1);
      chk("R8 reset we", ram_we_n, 1'b1);
      boot_force = 1'b1;
      tick();
      chk("R9 boot in reset", bank_sel, 1'b1);
      boot_force = 1'b0;
      tick();
      chk("R10 boot released", bank_sel, 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R2 after reset", bank_sel, 1'b0);

      for (int c = 0; c < 4; c++) begin
         rd_n = c[0]; fetch_n = c[1];
         tick();
         chk("R7 sweep", ram_oe_n, exp_oe(rd_n, fetch_n));
         chk("R2 sweep bank", bank_sel, 1'b0);
      end
      rd_n = 1'b1; fetch_n = 1'b1;
      tick();

      // Directed cases: a fetch then a write, and a write under boot override.
      bus_cycle(0, 1'b0);
      bus_cycle(2, 1'b0);
      bus_cycle(2, 1'b1);
      bus_cycle(0, 1'b1);

      for (int n = 0; n < NUM_CYCLES; n++) begin
         bus_cycle($urandom % 3, ($urandom % 8) == 0);
      end

      // Reset after activity returns the bank to data.
      bus_cycle(0, 1'b0);
      rst_n = 1'b0;
      tick();
      tick();
      chk("R2 reset mid-run", bank_sel, 1'b0);
      rst_n = 1'b1;
      tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WDOG_CLKS) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule